// File: doc/BRIEF.md
# Multi-vector broadcast add unit

The unit holds a file of 32 vector registers, each `VL` bits wide, and executes a single kind of vector instruction against it. The instruction adds one source vector lane by lane to every register of a group of two or four consecutive registers. It then writes the sums back over that group. Lanes are 8, 16, 32 or 64 bits wide. Each sum wraps at the lane width, and no predicate masks any lane.

A 32-bit instruction word is offered with a valid/ready handshake and is taken on the cycle where both are high. The control walks the group one register per cycle and buffers each sum. It then commits the whole group in a single write cycle, so every source read is finished before any register changes. A one-cycle done pulse ends each instruction. A word that does not decode, or any word given while the feature-enable input is low, ends instead in a done pulse with the undefined flag set, and no register changes. A debug port loads registers and reads them back.

Top module: `mvadd_unit`

## Requirements
- R1: A word is legal only when bits 31..24 are 8'hC1, bit 21 is 1, bit 20 is 0, bits 15..12 are 4'b1010, bits 10..5 are 6'b011000, bit 0 is 0, and bit 1 is 0 whenever bit 11 is 1. Any other word sets undefFlag together with donePulse in the cycle after acceptance and leaves every register unchanged.
- R2: Bit 11 selects the group. With 0 there are two registers based at 2×bits[4:1]. With 1 there are four registers based at 4×bits[4:2].
- R3: Bits 23..22 give the lane width as 8 << size (0→8, 1→16, 2→32, 3→64 bits).
- R4: The broadcast source is register bits[19:16] (0 to 15). Registers 16 to 31 are never the source.
- R5: Each result lane is the sum of the two source lanes modulo 2^width. No carry crosses a lane boundary.
- R6: Every lane of every group register is overwritten with its sum. All registers outside the group keep their values.
- R7: When featEn is low at acceptance, the word produces undefFlag with donePulse one cycle later, and no register changes.
- R8: When the source register lies inside the group, every sum uses the value the source held before the instruction.
- R9: instReady is high only while the unit is idle. It stays low from the acceptance edge until the done cycle has passed.
- R10: For a legal word, donePulse is high for exactly one cycle, N+2 cycles after the acceptance edge (N = group size). undefFlag is never high without donePulse.
- R11: While idle, a debug write stores dbgWrData into register dbgAddr at the clock edge. dbgRdData always shows register dbgAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| featEn | input | 1 | Instruction enable; low makes every word undefined |
| instValid | input | 1 | Instruction word offered |
| instReady | output | 1 | Unit idle and able to take a word |
| instWord | input | 32 | Instruction word |
| donePulse | output | 1 | One-cycle end-of-instruction strobe |
| undefFlag | output | 1 | Word was rejected (valid only with donePulse) |
| dbgWrEn | input | 1 | Debug register write strobe |
| dbgAddr | input | 5 | Debug register index |
| dbgWrData | input | VL | Debug write data |
| dbgRdData | output | VL | Contents of register dbgAddr |

## Verification
The checker watches the handshake and strobes on every cycle. It requires that ready drops after each acceptance, that done lasts one cycle, that undefined appears only with done and always follows acceptance with the enable low, and that a normal done follows a busy cycle. Lane arithmetic, carry isolation at each width, group base decoding, the restricted source range and the use of the original source value when it overlaps the group can only be shown by the bench's scenarios. The bench loads known data and compares every register after each instruction. The same holds for exact done latency and for registers staying unchanged after rejected words.

// File: rtl/mvadd_pkg.sv
package mvadd_pkg;
  localparam int REG_COUNT = 32;
  localparam int IDX_W     = $clog2(REG_COUNT);
  localparam int MAX_GROUP = 4;
  localparam int SLOT_W    = $clog2(MAX_GROUP);

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_DONE, ST_FAIL
  } state_e;

  typedef struct packed {
    logic              capture;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  srcIdx;
    logic [IDX_W-1:0]  bcastIdx;
    logic [1:0]        sizeSel;
    logic              commit;
    logic              fourGroup;
    logic [IDX_W-1:0]  groupBase;
    logic              dbgAllow;
  } strobes_t;
endpackage

// File: rtl/mvadd_ctrl.sv
module mvadd_ctrl
  import mvadd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        featEn,
  input  logic        instValid,
  input  logic [31:0] instWord,
  output logic        instReady,
  output logic        donePulse,
  output logic        undefFlag,
  output strobes_t    strb
);
  state_e            state;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  base;
  logic [IDX_W-1:0]  bcast;
  logic [1:0]        sizeSel;
  logic              four;

  logic              legal;
  logic              wFour;
  logic [IDX_W-1:0]  wBase;

  // Decode of the offered word
  always_comb begin
    wFour = instWord[11];
    legal = (instWord[31:24] == 8'hC1) && instWord[21] && !instWord[20] &&
            (instWord[15:12] == 4'b1010) && (instWord[10:5] == 6'b011000) &&
            !instWord[0] && !(wFour && instWord[1]);
    wBase = wFour ? {instWord[4:2], 2'b00} : {instWord[4:1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slot    <= '0;
      base    <= '0;
      bcast   <= '0;
      sizeSel <= '0;
      four    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (instValid) begin
          if (legal && featEn) begin
            state   <= ST_READ;
            slot    <= '0;
            base    <= wBase;
            bcast   <= {1'b0, instWord[19:16]};
            sizeSel <= instWord[23:22];
            four    <= wFour;
          end else begin
            state <= ST_FAIL;
          end
        end
        ST_READ: begin
          slot <= slot + 1'b1;
          if (slot == (four ? SLOT_W'(3) : SLOT_W'(1))) state <= ST_WRITE;
        end
        ST_WRITE: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    instReady      = (state == ST_IDLE);
    donePulse      = (state == ST_DONE) || (state == ST_FAIL);
    undefFlag      = (state == ST_FAIL);
    strb.capture   = (state == ST_READ);
    strb.slot      = slot;
    strb.srcIdx    = base + IDX_W'(slot);
    strb.bcastIdx  = bcast;
    strb.sizeSel   = sizeSel;
    strb.commit    = (state == ST_WRITE);
    strb.fourGroup = four;
    strb.groupBase = base;
    strb.dbgAllow  = (state == ST_IDLE);
  end
endmodule

// File: rtl/mvadd_dpath.sv
module mvadd_dpath
  import mvadd_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic             dbgWrEn,
  input  logic [IDX_W-1:0] dbgAddr,
  input  logic [VL-1:0]    dbgWrData,
  output logic [VL-1:0]    dbgRdData
);
  localparam int CHUNKS = VL / 8;

  logic [VL-1:0] regFile [REG_COUNT];
  logic [VL-1:0] resBuf  [MAX_GROUP];
  logic [VL-1:0] opA, opB, laneSum;

  assign opA       = regFile[strb.srcIdx];
  assign opB       = regFile[strb.bcastIdx];
  assign dbgRdData = regFile[dbgAddr];

  // Byte-chunk adder; carry is cut wherever a lane begins
  always_comb begin
    logic       cy;
    logic [8:0] part;
    logic [2:0] lowMask;
    cy      = 1'b0;
    laneSum = '0;
    lowMask = 3'((1 << strb.sizeSel) - 1);
    for (int i = 0; i < CHUNKS; i++) begin
      if ((3'(i) & lowMask) == 3'd0) cy = 1'b0;
      part = {1'b0, opA[i*8 +: 8]} + {1'b0, opB[i*8 +: 8]} + {8'd0, cy};
      laneSum[i*8 +: 8] = part[7:0];
      cy = part[8];
    end
  end

  for (genvar r = 0; r < MAX_GROUP; r++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) resBuf[r] <= '0;
      else if (strb.capture && (strb.slot == SLOT_W'(r))) resBuf[r] <= laneSum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (strb.commit) begin
      for (int r = 0; r < MAX_GROUP; r++)
        if (r < 2 || strb.fourGroup) regFile[strb.groupBase + IDX_W'(r)] <= resBuf[r];
    end else if (dbgWrEn && strb.dbgAllow) begin
      regFile[dbgAddr] <= dbgWrData;
    end
  end
endmodule

// File: rtl/mvadd_unit.sv
module mvadd_unit
  import mvadd_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          featEn,
  input  logic          instValid,
  output logic          instReady,
  input  logic [31:0]   instWord,
  output logic          donePulse,
  output logic          undefFlag,
  input  logic          dbgWrEn,
  input  logic [4:0]    dbgAddr,
  input  logic [VL-1:0] dbgWrData,
  output logic [VL-1:0] dbgRdData
);
  strobes_t strb;

  mvadd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .featEn(featEn), .instValid(instValid),
    .instWord(instWord), .instReady(instReady), .donePulse(donePulse),
    .undefFlag(undefFlag), .strb(strb)
  );

  mvadd_dpath #(.VL(VL)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .dbgWrEn(dbgWrEn),
    .dbgAddr(dbgAddr), .dbgWrData(dbgWrData), .dbgRdData(dbgRdData)
  );
endmodule

// File: rtl/mvadd_chk.sv
module mvadd_chk (
  input logic clk,
  input logic rstN,
  input logic featEn,
  input logic instValid,
  input logic instReady,
  input logic donePulse,
  input logic undefFlag
);
  // R9
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> !instReady);
  // R9
  done_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !instReady);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R10
  undef_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> donePulse);
  // R7
  disabled_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady && !featEn) |=> undefFlag);
  // R10
  legal_done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && !undefFlag) |-> $past(!instReady && !donePulse));
endmodule

bind mvadd_unit mvadd_chk u_chk (
  .clk(clk), .rstN(rstN), .featEn(featEn), .instValid(instValid),
  .instReady(instReady), .donePulse(donePulse), .undefFlag(undefFlag)
);

// File: tb/mvadd_unit_tb.sv
module mvadd_unit_tb;
  localparam int VL = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          featEn = 1'b1;
  logic          instValid = 1'b0;
  logic          instReady;
  logic [31:0]   instWord = '0;
  logic          donePulse, undefFlag;
  logic          dbgWrEn = 1'b0;
  logic [4:0]    dbgAddr = '0;
  logic [VL-1:0] dbgWrData = '0;
  logic [VL-1:0] dbgRdData;

  int checks = 0;
  int errors = 0;
  logic [VL-1:0] shadow [32];

  always #5 clk = ~clk;

  mvadd_unit #(.VL(VL)) u_dut (.*);

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not end (actual hung, expected finished)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int sz, int zm, int zdn, bit four);
    logic [31:0] w;
    w = 32'hC120_A300;
    w[23:22] = 2'(sz);
    w[19:16] = 4'(zm);
    w[11] = four;
    if (four) w[4:2] = 3'(zdn); else w[4:1] = 4'(zdn);
    return w;
  endfunction

  function automatic logic [VL-1:0] vadd(logic [VL-1:0] a, logic [VL-1:0] b, int sz);
    logic [VL-1:0] r;
    logic [63:0] x, y, m;
    int es;
    es = 8 << sz;
    m = (es == 64) ? '1 : ((64'd1 << es) - 1);
    r = '0;
    for (int e = 0; e < VL / es; e++) begin
      x = 64'(a >> (e * es)) & m;
      y = 64'(b >> (e * es)) & m;
      r = r | (VL'((x + y) & m) << (e * es));
    end
    return r;
  endfunction

  task automatic load(int idx, logic [VL-1:0] d);
    @(negedge clk);
    dbgWrEn = 1'b1; dbgAddr = 5'(idx); dbgWrData = d;
    @(posedge clk); #1;
    dbgWrEn = 1'b0;
    shadow[idx] = d;
  endtask

  task automatic fillAll();
    for (int i = 0; i < 32; i++)
      load(i, {$urandom(), $urandom(), $urandom(), $urandom()});
  endtask

  task automatic compareAll(string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      dbgAddr = 5'(i);
      #1;
      chk(req, dbgRdData, shadow[i]);
    end
  endtask

  // Issue a word, check handshake and done timing; expLat = cycles to done
  task automatic issue(logic [31:0] w, bit expUndef, int expLat, string req);
    int n;
    @(negedge clk);
    instWord = w; instValid = 1'b1;
    @(posedge clk); #1;
    instValid = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!donePulse) chk("R9 ready low while busy", VL'(instReady), VL'(0));
    end while (!donePulse && n < 20);
    chk({req, " done latency"}, VL'(n), VL'(expLat));
    chk({req, " undef flag"}, VL'(undefFlag), VL'(expUndef));
    chk("R9 ready low in done cycle", VL'(instReady), VL'(0));
    @(negedge clk);
    chk("R10 done one cycle", VL'(donePulse), VL'(0));
    chk("R9 ready back", VL'(instReady), VL'(1));
  endtask

  task automatic runOp(int sz, int zm, int zdn, bit four, string req);
    logic [VL-1:0] orig [32];
    int base, cnt;
    for (int i = 0; i < 32; i++) orig[i] = shadow[i];
    cnt = four ? 4 : 2;
    base = four ? zdn * 4 : zdn * 2;
    for (int r = 0; r < cnt; r++) shadow[base + r] = vadd(orig[base + r], orig[zm], sz);
    issue(mk(sz, zm, zdn, four), 1'b0, cnt + 2, "R10");
    compareAll(req);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R9 reset ready", VL'(instReady), VL'(1));
    chk("R10 reset done", VL'(donePulse), VL'(0));
    chk("R10 reset undef", VL'(undefFlag), VL'(0));
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    compareAll("R11 reset contents");
  endtask

  task automatic testDebug();
    load(7, {4{32'hDEAD_BEEF}});
    compareAll("R11 debug write/read");
  endtask

  task automatic testByteWrap();
    load(2, {16{8'hFF}});
    load(3, {8{16'h7FFF}});
    load(9, {16{8'h01}});
    runOp(0, 9, 1, 1'b0, "R5 R2 byte wrap two-group");
    chk("R5 byte no carry", shadow[2], '0);
  endtask

  task automatic testWidths();
    fillAll();
    runOp(1, 3, 2, 1'b1, "R3 R6 16-bit four-group");
    runOp(2, 14, 5, 1'b1, "R3 R6 32-bit four-group");
    load(20, {2{64'hFFFF_FFFF_FFFF_FFFF}});
    load(1, {2{64'h0000_0000_0000_0001}});
    runOp(3, 1, 10, 1'b0, "R3 R5 64-bit wrap");
    chk("R5 64-bit result", shadow[20], '0);
    runOp(0, 0, 15, 1'b0, "R2 top two-group");
  endtask

  task automatic testOverlap();
    fillAll();
    runOp(1, 5, 1, 1'b1, "R8 source inside four-group");
    runOp(2, 12, 6, 1'b0, "R8 source first of two-group");
  endtask

  task automatic testSrcRange();
    fillAll();
    runOp(0, 15, 0, 1'b0, "R4 source 15 not 31");
  endtask

  task automatic testReject();
    fillAll();
    featEn = 1'b0;
    issue(mk(0, 1, 2, 1'b0), 1'b1, 1, "R7");
    featEn = 1'b1;
    compareAll("R7 no change when disabled");
    issue(mk(0, 1, 2, 1'b0) ^ 32'h0000_1000, 1'b1, 1, "R1 bad fixed bit");
    issue(mk(0, 1, 2, 1'b0) | 32'h1, 1'b1, 1, "R1 bit0 set");
    issue(mk(0, 1, 1, 1'b1) | 32'h2, 1'b1, 1, "R1 four-group bit1 set");
    issue(32'h0, 1'b1, 1, "R1 zero word");
    compareAll("R1 no change on undefined");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testDebug();
    testByteWrap();
    testWidths();
    testOverlap();
    testSrcRange();
    testReject();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule